// File: doc/BRIEF.md
# Configuration Command Port

This block is the register front end of a configuration controller. Software sees three word registers: a data word, a command word and a two-bit status word. Writing the command word starts the command at once. The block checks the written word against two known command codes, sends a one-cycle shutdown or reboot request for a match, and marks the status as done, plus an error flag when nothing matched. No command waits for anything. Completion is reported in the same write.

The port is fitted only on one board variant. A strap input says whether it is present. When the strap is low, the three register offsets behave as bad accesses: reads give zero and writes leave everything as it was. Reads are combinational on the address. Writes take effect on the rising clock edge where the write enable is sampled high.

Top module: `cfgcmd_port`

## Requirements
- R1: After reset, the data, command and status registers all read as zero, and both request outputs are low.
- R2: The data register at byte offset 0xA0 stores all 32 bits of a write, and a read returns them unchanged.
- R3: A write to the command register at offset 0xA4 stores the written word with bits 19 and 18 forced to zero and bit 31 (start) forced to zero.
- R4: Every write to the command register sets status bit 0 (done). A read of the status register at offset 0xA8 returns the status in bits 1:0 and zero above them.
- R5: A command word equal to 0xC0800000 after bits 19:18 are cleared makes shutdownReq high for exactly the one cycle after the write edge, and leaves status at 0b01.
- R6: A command word equal to 0xC0900000 after bits 19:18 are cleared makes rebootReq high for exactly the one cycle after the write edge, and leaves status at 0b01.
- R7: Any other command word, including a recognised code with bit 31 clear, sets status to 0b11 (done and error) and raises no request.
- R8: The command match ignores written bits 19:18, so 0xC08C0000 is treated as the shutdown command.
- R9: A write to the status register stores only bits 1:0 of the data, which also clears a previous error flag.
- R10: While portPresent is low, reads of the three offsets return zero, and writes to them change no register and raise no request.
- R11: Accesses to any other address, including unaligned ones such as 0xA1, read zero and change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| portPresent | input | 1 | Strap: high on the board variant that has the port |
| wrEn | input | 1 | Write strobe, sampled on the rising edge |
| rdEn | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, zero when no register is selected |
| shutdownReq | output | 1 | One-cycle shutdown request |
| rebootReq | output | 1 | One-cycle reboot request |

## Verification
The hardest case to reach is the command match on a masked word. The written word differs from a recognised code only in bits 19:18, or only in the start bit. The first must still fire the request, and the second must instead report an error. The directed stimulus writes such near-miss words next to the exact codes. The pulse is sampled in the cycle after the edge and again one cycle later. The stored word is read back each time to confirm both forced-zero fields. The absent-variant case writes with the strap low and then raises the strap to read the registers back. This proves the earlier writes changed nothing.

// File: rtl/cfgcmd_pkg.sv
`timescale 1ns/1ps
package cfgcmd_pkg;
  localparam int WORD_W  = 32;
  localparam int STAT_W  = 2;
  localparam int NUM_REG = 3;

  // register index order: data, command, status
  localparam int REG_DATA = 0;
  localparam int REG_CMD  = 1;
  localparam int REG_STAT = 2;
  localparam int REG_OFFSET [NUM_REG] = '{'hA0, 'hA4, 'hA8};

  localparam int START_BIT = 31;
  localparam logic [WORD_W-1:0] CMD_FORCE_ZERO = 32'h000C_0000;
  localparam logic [WORD_W-1:0] CODE_SHUTDOWN  = 32'hC080_0000;
  localparam logic [WORD_W-1:0] CODE_REBOOT    = 32'hC090_0000;

  typedef struct packed {
    logic dataWr;
    logic cmdWr;
    logic statWr;
    logic dataRd;
    logic cmdRd;
    logic statRd;
    logic hitShutdown;
    logic hitReboot;
    logic hitNone;
  } cmdStrobes_t;
endpackage

// File: rtl/cfgcmd_ctrl.sv
`timescale 1ns/1ps
module cfgcmd_ctrl
  import cfgcmd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              portPresent,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  output cmdStrobes_t       strobes
);
  logic [NUM_REG-1:0] regSel;
  logic [WORD_W-1:0]  maskedCmd;
  logic               isShutdown;
  logic               isReboot;

  for (genvar i = 0; i < NUM_REG; i++) begin : g_decode
    assign regSel[i] = portPresent && (addr == ADDR_W'(REG_OFFSET[i]));
  end

  assign maskedCmd  = wrData & ~CMD_FORCE_ZERO;
  assign isShutdown = (maskedCmd == CODE_SHUTDOWN);
  assign isReboot   = (maskedCmd == CODE_REBOOT);

  always_comb begin
    strobes             = '0;
    strobes.dataWr      = wrEn && regSel[REG_DATA];
    strobes.cmdWr       = wrEn && regSel[REG_CMD];
    strobes.statWr      = wrEn && regSel[REG_STAT];
    strobes.dataRd      = rdEn && regSel[REG_DATA];
    strobes.cmdRd       = rdEn && regSel[REG_CMD];
    strobes.statRd      = rdEn && regSel[REG_STAT];
    strobes.hitShutdown = strobes.cmdWr && isShutdown;
    strobes.hitReboot   = strobes.cmdWr && isReboot;
    strobes.hitNone     = strobes.cmdWr && !isShutdown && !isReboot;
  end
endmodule

// File: rtl/cfgcmd_datapath.sv
`timescale 1ns/1ps
module cfgcmd_datapath
  import cfgcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobes_t       strobes,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] dataQ,
  output logic [WORD_W-1:0] cmdQ,
  output logic [STAT_W-1:0] statQ,
  output logic              shutdownReq,
  output logic              rebootReq
);
  localparam logic [WORD_W-1:0] START_MASK = WORD_W'(1) << START_BIT;
  localparam logic [WORD_W-1:0] CMD_KEEP   = ~(CMD_FORCE_ZERO | START_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
    end else if (strobes.dataWr) begin
      dataQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ <= '0;
    end else if (strobes.cmdWr) begin
      cmdQ <= wrData & CMD_KEEP;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ <= '0;
    end else if (strobes.cmdWr) begin
      statQ <= {strobes.hitNone, 1'b1};
    end else if (strobes.statWr) begin
      statQ <= wrData[STAT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shutdownReq <= 1'b0;
      rebootReq   <= 1'b0;
    end else begin
      shutdownReq <= strobes.hitShutdown;
      rebootReq   <= strobes.hitReboot;
    end
  end
endmodule

// File: rtl/cfgcmd_port.sv
`timescale 1ns/1ps
module cfgcmd_port
  import cfgcmd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portPresent,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              shutdownReq,
  output logic              rebootReq
);
  cmdStrobes_t       strobes;
  logic [WORD_W-1:0] dataQ;
  logic [WORD_W-1:0] cmdQ;
  logic [STAT_W-1:0] statQ;

  cfgcmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .portPresent (portPresent),
    .wrEn        (wrEn),
    .rdEn        (rdEn),
    .addr        (addr),
    .wrData      (wrData),
    .strobes     (strobes)
  );

  cfgcmd_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrData      (wrData),
    .dataQ       (dataQ),
    .cmdQ        (cmdQ),
    .statQ       (statQ),
    .shutdownReq (shutdownReq),
    .rebootReq   (rebootReq)
  );

  always_comb begin
    rdData = '0;
    if (strobes.dataRd)      rdData = dataQ;
    else if (strobes.cmdRd)  rdData = cmdQ;
    else if (strobes.statRd) rdData = {{(WORD_W-STAT_W){1'b0}}, statQ};
  end
endmodule

// File: rtl/cfgcmd_port_chk.sv
`timescale 1ns/1ps
module cfgcmd_port_chk
  import cfgcmd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              portPresent,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic [31:0]       rdData,
  input logic              shutdownReq,
  input logic              rebootReq,
  input logic [31:0]       dataQ,
  input logic [31:0]       cmdQ,
  input logic [1:0]        statQ
);
  logic        atCmd, atStat, inWindow;
  logic        cmdWrite, statWrite;
  logic [31:0] cleaned;

  assign atCmd     = (addr == ADDR_W'(REG_OFFSET[REG_CMD]));
  assign atStat    = (addr == ADDR_W'(REG_OFFSET[REG_STAT]));
  assign inWindow  = atCmd || atStat || (addr == ADDR_W'(REG_OFFSET[REG_DATA]));
  assign cmdWrite  = wrEn && portPresent && atCmd;
  assign statWrite = wrEn && portPresent && atStat;
  assign cleaned   = {1'b1, wrData[30:20], 2'b00, wrData[17:0]};

  assert_cmd_fields_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrite |=> (cmdQ[31] == 1'b0 && cmdQ[19:18] == 2'b00));

  assert_done_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrite |=> statQ[0]);

  assert_shutdown_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |=> !shutdownReq);

  assert_shutdown_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> $past(cmdWrite && wrData[31] && cleaned == 32'hC080_0000));

  assert_reboot_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    rebootReq |-> $past(cmdWrite && wrData[31] && cleaned == 32'hC090_0000));

  assert_single_request_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(shutdownReq && rebootReq));

  assert_error_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && !(wrData[31] && (cleaned == 32'hC080_0000 || cleaned == 32'hC090_0000)))
      |=> (statQ == 2'b11));

  assert_status_store_R9: assert property (@(posedge clk) disable iff (!rstN)
    statWrite |=> (statQ == $past(wrData[1:0])));

  assert_absent_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!portPresent && rdEn && inWindow) |-> (rdData == 32'h0));

  assert_absent_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!portPresent && wrEn) |=> ($stable(dataQ) && $stable(cmdQ) && $stable(statQ)
                               && !shutdownReq && !rebootReq));
endmodule

bind cfgcmd_port cfgcmd_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .portPresent (portPresent),
  .wrEn        (wrEn),
  .rdEn        (rdEn),
  .addr        (addr),
  .wrData      (wrData),
  .rdData      (rdData),
  .shutdownReq (shutdownReq),
  .rebootReq   (rebootReq),
  .dataQ       (dataQ),
  .cmdQ        (cmdQ),
  .statQ       (statQ)
);

// File: tb/cfgcmd_port_test.sv
`timescale 1ns/1ps
module cfgcmd_port_test;
  localparam int ADDR_W = 8;
  localparam logic [7:0] A_DATA = 8'hA0;
  localparam logic [7:0] A_CMD  = 8'hA4;
  localparam logic [7:0] A_STAT = 8'hA8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              portPresent = 1'b1;
  logic              wrEn = 1'b0;
  logic              rdEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wrData = '0;
  logic [31:0]       rdData;
  logic              shutdownReq, rebootReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cfgcmd_port #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .portPresent(portPresent), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData),
    .shutdownReq(shutdownReq), .rebootReq(rebootReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // drive at falling edge, the rising edge in between commits the write
  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; addr = '0; wrData = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    rdEn = 1'b0; addr = '0;
  endtask

  task automatic expectRead(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRead(a, v);
    check(req, v, exp);
  endtask

  // called right after busWrite: pulse visible now, gone one cycle later
  task automatic expectPulses(input string req, input logic sd, input logic rb);
    check({req, " shutdown"}, {31'b0, shutdownReq}, {31'b0, sd});
    check({req, " reboot"}, {31'b0, rebootReq}, {31'b0, rb});
    @(negedge clk);
    check({req, " shutdown end"}, {31'b0, shutdownReq}, 32'h0);
    check({req, " reboot end"}, {31'b0, rebootReq}, 32'h0);
  endtask

  task automatic testReset();
    expectRead("R1 data", A_DATA, 32'h0);
    expectRead("R1 cmd", A_CMD, 32'h0);
    expectRead("R1 status", A_STAT, 32'h0);
    check("R1 shutdown", {31'b0, shutdownReq}, 32'h0);
    check("R1 reboot", {31'b0, rebootReq}, 32'h0);
  endtask

  task automatic testDataReg();
    busWrite(A_DATA, 32'hDEAD_BEEF);
    expectRead("R2 data a", A_DATA, 32'hDEAD_BEEF);
    busWrite(A_DATA, 32'h1234_5678);
    expectRead("R2 data b", A_DATA, 32'h1234_5678);
  endtask

  task automatic testShutdown();
    busWrite(A_CMD, 32'hC080_0000);
    expectPulses("R5", 1'b1, 1'b0);
    expectRead("R3 cmd start cleared", A_CMD, 32'h4080_0000);
    expectRead("R5 status", A_STAT, 32'h1);
  endtask

  task automatic testReboot();
    busWrite(A_CMD, 32'hC090_0000);
    expectPulses("R6", 1'b0, 1'b1);
    expectRead("R3 cmd", A_CMD, 32'h4090_0000);
    expectRead("R6 status", A_STAT, 32'h1);
  endtask

  task automatic testMaskedMatch();
    busWrite(A_CMD, 32'hC08C_0000);
    expectPulses("R8", 1'b1, 1'b0);
    expectRead("R8 cmd stored", A_CMD, 32'h4080_0000);
    expectRead("R8 status", A_STAT, 32'h1);
  endtask

  task automatic testError();
    busWrite(A_CMD, 32'h4080_0000);
    expectPulses("R7 no start", 1'b0, 1'b0);
    expectRead("R7 status", A_STAT, 32'h3);
    busWrite(A_CMD, 32'hFFFF_FFFF);
    expectPulses("R7 all ones", 1'b0, 1'b0);
    expectRead("R3 forced zero fields", A_CMD, 32'h7FF3_FFFF);
    expectRead("R7 status b", A_STAT, 32'h3);
  endtask

  task automatic testStatusWrite();
    busWrite(A_STAT, 32'hFFFF_FFFE);
    expectRead("R9 low bits only", A_STAT, 32'h2);
    busWrite(A_STAT, 32'h0);
    expectRead("R9 cleared", A_STAT, 32'h0);
    busWrite(A_CMD, 32'h0000_0001);
    expectRead("R4 done after error cmd", A_STAT, 32'h3);
    busWrite(A_CMD, 32'hC090_0000);
    expectPulses("R4 reboot", 1'b0, 1'b1);
    expectRead("R4 error cleared by good cmd", A_STAT, 32'h1);
  endtask

  task automatic testAbsent();
    busWrite(A_DATA, 32'h5555_AAAA);
    @(negedge clk) portPresent = 1'b0;
    expectRead("R10 data reads zero", A_DATA, 32'h0);
    expectRead("R10 cmd reads zero", A_CMD, 32'h0);
    expectRead("R10 status reads zero", A_STAT, 32'h0);
    busWrite(A_DATA, 32'h0BAD_0BAD);
    busWrite(A_STAT, 32'h2);
    busWrite(A_CMD, 32'hC080_0000);
    expectPulses("R10 no request", 1'b0, 1'b0);
    @(negedge clk) portPresent = 1'b1;
    expectRead("R10 data kept", A_DATA, 32'h5555_AAAA);
    expectRead("R10 cmd kept", A_CMD, 32'h4090_0000);
    expectRead("R10 status kept", A_STAT, 32'h1);
  endtask

  task automatic testOtherAddr();
    busWrite(8'hA1, 32'hFFFF_FFFF);
    busWrite(8'hAC, 32'hFFFF_FFFF);
    busWrite(8'h00, 32'hC080_0000);
    expectPulses("R11 no request", 1'b0, 1'b0);
    expectRead("R11 read 0xAC", 8'hAC, 32'h0);
    expectRead("R11 read 0xA1", 8'hA1, 32'h0);
    expectRead("R11 data kept", A_DATA, 32'h5555_AAAA);
    expectRead("R11 cmd kept", A_CMD, 32'h4090_0000);
    expectRead("R11 status kept", A_STAT, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDataReg();
    testShutdown();
    testReboot();
    testMaskedMatch();
    testError();
    testStatusWrite();
    testAbsent();
    testOtherAddr();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule